// File: doc/BRIEF.md
# Floating-Point Fault Locator Register

This block keeps a record of the most recent floating-point instruction, so that a fault handler can later find out which instruction was running and which memory location it used. Each time the execution pipeline retires a floating-point instruction, the block stores three things: the instruction's address, the part of its opcode that varies, and the address of its memory operand if it has one.

The stored values are always available as two packed 32-bit words. Together they form a 64-bit record. The instruction word holds the 20-bit address and the 11 varying opcode bits. The data word holds the 20-bit operand address. A mode input selects which address is stored as the instruction address when the instruction has a segment override prefix. In one setting it is the address of the prefix byte. In the other it is the address of the escape opcode byte.

The opcode of every floating-point instruction starts with the fixed bits 11011b, so those five bits are not stored. The block adds them back when it presents the opcode as a full 16-bit value.

Top module: `fpx_locator`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, sets both packed words to zero. The reconstructed opcode then reads 16'hD800.
- R2: When `retire_vld` is high at a rising edge, bits 10:0 of `opc_in` appear in `ip_word[31:21]` from that edge on.
- R3: On a retire with `keep_prefix` low, or with `pfx_vld` low, `ip_word[19:0]` takes the value of `insn_addr`.
- R4: On a retire with both `keep_prefix` and `pfx_vld` high, `ip_word[19:0]` takes the value of `pfx_addr`.
- R5: On a retire with `mem_vld` high, `dp_word[19:0]` takes the value of `opnd_addr`.
- R6: On a retire with `mem_vld` low, `dp_word` keeps its previous value, and `opnd_addr` has no effect.
- R7: At an edge with `retire_vld` low, both words and `opc_full` keep their values, whatever the other inputs do.
- R8: `ip_word[20]` and `dp_word[31:20]` always read zero.
- R9: `opc_full` equals the escape pattern 11011b in bits 15:11, with the stored 11 opcode bits in bits 10:0.
- R10: Bits 15:11 of `opc_in` are not stored. A capture whose opcode has other values in those bits still reads back 11011b there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| retire_vld | input | 1 | A floating-point instruction retires in this cycle |
| insn_addr | input | 20 | Physical address of the escape opcode byte |
| pfx_vld | input | 1 | The instruction carries a segment override prefix |
| pfx_addr | input | 20 | Physical address of the prefix byte |
| keep_prefix | input | 1 | Mode: 1 records the prefix address when one is present |
| opc_in | input | 16 | Both opcode bytes of the instruction |
| mem_vld | input | 1 | The instruction has a memory operand |
| opnd_addr | input | 20 | Physical address of the memory operand |
| ip_word | output | 32 | Packed word: instruction address in bits 19:0, opcode in bits 31:21 |
| dp_word | output | 32 | Packed word: operand address in bits 19:0 |
| opc_full | output | 16 | Stored opcode with the escape pattern restored |

## Verification
A wrong capture shows up one edge after the retire strobe. It appears as a wrong address field, a wrong opcode field or a wrong operand field in the packed words, so a comparison made in every cycle catches it at once. Some errors change state without showing at once. Examples are a data pointer that is overwritten by a retire without a memory operand, or a capture that fires with no strobe. These are found at the next comparison, because the block only holds values and the reference model keeps track of them on every clock. The prefix selection is exercised with all four combinations of mode and prefix presence, using addresses that differ from each other.

// File: rtl/fpx_locator_pkg.sv
package fpx_locator_pkg;
    parameter int FPX_ADDR_W = 20;
    parameter int FPX_OPC_W  = 16;
    parameter int FPX_KEEP_W = 11;
    localparam int FPX_ESC_W = FPX_OPC_W - FPX_KEEP_W;
    parameter logic [FPX_ESC_W-1:0] FPX_ESC_CODE = 5'b11011;

    typedef struct packed {
        logic [FPX_ADDR_W-1:0] ip_addr;
        logic [FPX_KEEP_W-1:0] opc;
        logic [FPX_ADDR_W-1:0] dp_addr;
    } fpx_rec_t;
endpackage

// File: rtl/fpx_addr_sel.sv
module fpx_addr_sel
    import fpx_locator_pkg::*;
(
    input  logic [FPX_ADDR_W-1:0] insn_addr,
    input  logic [FPX_ADDR_W-1:0] pfx_addr,
    input  logic                  pfx_vld,
    input  logic                  keep_prefix,
    output logic [FPX_ADDR_W-1:0] sel_addr
);
    // The prefix address is taken only when the mode asks for it and a prefix exists
    always_comb begin
        if (keep_prefix && pfx_vld) sel_addr = pfx_addr;
        else                        sel_addr = insn_addr;
    end
endmodule

// File: rtl/fpx_rec_regs.sv
module fpx_rec_regs
    import fpx_locator_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap,
    input  logic                  mem_vld,
    input  logic [FPX_ADDR_W-1:0] sel_addr,
    input  logic [FPX_KEEP_W-1:0] opc_keep,
    input  logic [FPX_ADDR_W-1:0] opnd_addr,
    output fpx_rec_t              rec_q
);
    fpx_rec_t rec_d;

    always_comb begin
        rec_d = rec_q;
        if (cap) begin
            rec_d.ip_addr = sel_addr;
            rec_d.opc     = opc_keep;
            if (mem_vld) rec_d.dp_addr = opnd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rec_q <= '0;
        else     rec_q <= rec_d;
    end

    // Operand field may only change on a retire that carries a memory operand
    assert_dp_guard_R6: assert property (@(posedge clk) disable iff (rst)
        !(cap && mem_vld) |=> $stable(rec_q.dp_addr));
endmodule

// File: rtl/fpx_rec_pack.sv
module fpx_rec_pack
    import fpx_locator_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  fpx_rec_t              rec_q,
    output logic [WORD_W-1:0]     ip_word,
    output logic [WORD_W-1:0]     dp_word,
    output logic [FPX_OPC_W-1:0]  opc_full
);
    localparam int GAP_W = WORD_W - FPX_KEEP_W - FPX_ADDR_W;
    localparam int DPAD_W = WORD_W - FPX_ADDR_W;

    generate
        if (GAP_W > 0) begin : g_gap
            assign ip_word = {rec_q.opc, {GAP_W{1'b0}}, rec_q.ip_addr};
        end else begin : g_nogap
            assign ip_word = {rec_q.opc, rec_q.ip_addr};
        end
    endgenerate

    assign dp_word  = {{DPAD_W{1'b0}}, rec_q.dp_addr};
    assign opc_full = {FPX_ESC_CODE, rec_q.opc};
endmodule

// File: rtl/fpx_locator.sv
module fpx_locator
    import fpx_locator_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  retire_vld,
    input  logic [FPX_ADDR_W-1:0] insn_addr,
    input  logic                  pfx_vld,
    input  logic [FPX_ADDR_W-1:0] pfx_addr,
    input  logic                  keep_prefix,
    input  logic [FPX_OPC_W-1:0]  opc_in,
    input  logic                  mem_vld,
    input  logic [FPX_ADDR_W-1:0] opnd_addr,
    output logic [WORD_W-1:0]     ip_word,
    output logic [WORD_W-1:0]     dp_word,
    output logic [FPX_OPC_W-1:0]  opc_full
);
    localparam int OPC_LSB = WORD_W - FPX_KEEP_W;

    logic [FPX_ADDR_W-1:0] sel_addr;
    fpx_rec_t              rec_q;

    fpx_addr_sel u_sel (
        .insn_addr  (insn_addr),
        .pfx_addr   (pfx_addr),
        .pfx_vld    (pfx_vld),
        .keep_prefix(keep_prefix),
        .sel_addr   (sel_addr)
    );

    fpx_rec_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cap      (retire_vld),
        .mem_vld  (mem_vld),
        .sel_addr (sel_addr),
        .opc_keep (opc_in[FPX_KEEP_W-1:0]),
        .opnd_addr(opnd_addr),
        .rec_q    (rec_q)
    );

    fpx_rec_pack #(.WORD_W(WORD_W)) u_pack (
        .rec_q   (rec_q),
        .ip_word (ip_word),
        .dp_word (dp_word),
        .opc_full(opc_full)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ip_word == '0) && (dp_word == '0));

    assert_opc_capture_R2: assert property (@(posedge clk) disable iff (rst)
        retire_vld |=> ip_word[WORD_W-1:OPC_LSB] == $past(opc_in[FPX_KEEP_W-1:0]));

    assert_plain_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && !(keep_prefix && pfx_vld)) |=> ip_word[FPX_ADDR_W-1:0] == $past(insn_addr));

    assert_prefix_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && keep_prefix && pfx_vld) |=> ip_word[FPX_ADDR_W-1:0] == $past(pfx_addr));

    assert_opnd_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && mem_vld) |=> dp_word[FPX_ADDR_W-1:0] == $past(opnd_addr));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !retire_vld |=> $stable(ip_word) && $stable(dp_word) && $stable(opc_full));
endmodule

// File: tb/sim_fpx_locator.sv
module sim_fpx_locator;
    logic        clk = 1'b0;
    logic        rst;
    logic        retire_vld;
    logic [19:0] insn_addr;
    logic        pfx_vld;
    logic [19:0] pfx_addr;
    logic        keep_prefix;
    logic [15:0] opc_in;
    logic        mem_vld;
    logic [19:0] opnd_addr;
    logic [31:0] ip_word;
    logic [31:0] dp_word;
    logic [15:0] opc_full;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state, kept as plain values
    logic [19:0] m_ip;
    logic [10:0] m_opc;
    logic [19:0] m_dp;

    always #2 clk = ~clk;

    fpx_locator u0 (
        .clk(clk), .rst(rst), .retire_vld(retire_vld), .insn_addr(insn_addr),
        .pfx_vld(pfx_vld), .pfx_addr(pfx_addr), .keep_prefix(keep_prefix),
        .opc_in(opc_in), .mem_vld(mem_vld), .opnd_addr(opnd_addr),
        .ip_word(ip_word), .dp_word(dp_word), .opc_full(opc_full)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare after the edge
    task automatic step(bit rv, logic [19:0] ia, bit pv, logic [19:0] pa, bit kp,
                        logic [15:0] op, bit mv, logic [19:0] oa);
        bit took_pfx;
        retire_vld = rv; insn_addr = ia; pfx_vld = pv; pfx_addr = pa;
        keep_prefix = kp; opc_in = op; mem_vld = mv; opnd_addr = oa;
        @(posedge clk);
        took_pfx = rv && kp && pv;
        if (rv) begin
            m_ip  = took_pfx ? pa : ia;
            m_opc = op[10:0];
            if (mv) m_dp = oa;
        end
        #1;
        if (!rv) begin
            check("R7 ip hold", ip_word, {m_opc, 1'b0, m_ip});
            check("R7 dp hold", dp_word, {12'h000, m_dp});
        end else begin
            check(took_pfx ? "R4 ip prefix addr" : "R3 ip insn addr",
                  {12'h000, ip_word[19:0]}, {12'h000, m_ip});
            check("R2 ip opcode field", {21'h0, ip_word[31:21]}, {21'h0, m_opc});
            check(mv ? "R5 dp operand" : "R6 dp kept", dp_word[19:0], {12'h000, m_dp});
            if (op[15:11] != 5'b11011)
                check("R10 escape bits restored", {27'h0, opc_full[15:11]}, 32'd27);
        end
        check("R8 ip gap bit", {31'h0, ip_word[20]}, 32'h0);
        check("R8 dp upper bits", {20'h0, dp_word[31:20]}, 32'h0);
        check("R9 opcode readout", {16'h0, opc_full}, {16'h0, 5'b11011, m_opc});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1;
        retire_vld = 1'b1; insn_addr = 20'hFFFFF; pfx_vld = 1'b1; pfx_addr = 20'hAAAAA;
        keep_prefix = 1'b1; opc_in = 16'hFFFF; mem_vld = 1'b1; opnd_addr = 20'h55555;
        repeat (3) @(posedge clk);
        #1;
        check("R1 ip after reset", ip_word, 32'h0);
        check("R1 dp after reset", dp_word, 32'h0);
        check("R1 opcode after reset", {16'h0, opc_full}, 32'h0000D800);
        m_ip = '0; m_opc = '0; m_dp = '0;
        rst = 1'b0;

        // Directed: every mode and prefix pairing
        step(1, 20'h12345, 0, 20'h12344, 0, 16'hD9C1, 1, 20'h0BEEF);
        step(1, 20'h22222, 1, 20'h22221, 0, 16'hDEF9, 0, 20'h77777);
        step(1, 20'h33333, 0, 20'h33332, 1, 16'hDC05, 0, 20'h66666);
        step(1, 20'h44444, 1, 20'h44443, 1, 16'hDD3E, 1, 20'h01234);
        // Idle cycles with noisy inputs
        step(0, 20'hFFFFF, 1, 20'hEEEEE, 1, 16'h07FF, 1, 20'hDDDDD);
        step(0, 20'h00000, 0, 20'h00000, 0, 16'h0000, 0, 20'h00000);
        // Top opcode bits other than the escape pattern
        step(1, 20'hFFFFF, 0, 20'h00000, 0, 16'h0123, 0, 20'hFFFFF);
        step(1, 20'h00001, 1, 20'hFFFFE, 1, 16'hFFFF, 1, 20'hFFFFF);
        // Back-to-back retires, operand only on the middle one
        step(1, 20'h10000, 0, 20'h0, 0, 16'hD800, 0, 20'h11111);
        step(1, 20'h10003, 0, 20'h0, 0, 16'hD801, 1, 20'h22222);
        step(1, 20'h10006, 0, 20'h0, 0, 16'hD802, 0, 20'h33333);

        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 3) != 0, 20'($urandom), 1'($urandom), 20'($urandom),
                 1'($urandom), 16'($urandom), 1'($urandom), 20'($urandom));
        end

        // Reset in mid-run clears captured state again
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 ip after second reset", ip_word, 32'h0);
        check("R1 dp after second reset", dp_word, 32'h0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule